// File: doc/BRIEF.md
# Crypto Ready Interrupt Controller

This block holds the completion status of a block-cipher engine and turns it into an interrupt request. When the engine pulses its done strobe, a ready flag is set. The interrupt request is raised while that flag, a local enable bit and the processor's global enable are all high.

Software clears the flag by acknowledging the interrupt. The flag is also cleared, as a side effect, by any bus access that starts new work or collects a result: a read of the result register, or a write to the data-input or key register.

Two resets act on the block. Power-up reset clears everything. Software reset clears the flag but leaves the local enable as it was. The block also drives a main-clock request while the engine is busy, so that a low-power clock setting cannot stop an operation partway through.

Top module: `crypto_rdy_irq_ctrl`

## Requirements
- R1: When `por_n` is low at a rising clock edge, `rdy_flag`, `ien` and the clock-request hold stage are cleared at that edge. With `eng_busy` low, `rdy_flag`, `ien`, `irq` and `clk_req` then read 0.
- R2: An `eng_done` pulse sets `rdy_flag` at the next rising edge.
- R3: Each of `irq_ack`, `rd_dout`, `wr_din` and `wr_key`, when sampled high, clears `rdy_flag` at the next rising edge.
- R4: If `eng_done` and any clear event from R3 are high in the same cycle, `rdy_flag` is set, so that a completion is not lost.
- R5: `sw_rst` clears `rdy_flag` at the next rising edge, and this overrides a simultaneous `eng_done`.
- R6: `sw_rst` leaves `ien` unchanged.
- R7: When `ien_wr` is high at a rising edge, `ien` takes the value of `ien_wdata`. Otherwise `ien` holds its value, apart from the effect of `por_n`.
- R8: `irq` is high exactly when `rdy_flag`, `ien` and `gie` are all high. It follows `gie` in the same cycle, with no register in that path.
- R9: `clk_req` is high in every cycle in which `eng_busy` is high, including the first cycle. It stays high for one more cycle after `eng_busy` falls, and then goes low.
- R10: With no set, clear or reset event, `rdy_flag` holds its value, regardless of `gie`, `ien_wr` or `eng_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-up reset, synchronous, active low |
| sw_rst | input | 1 | Software reset strobe, active high |
| eng_busy | input | 1 | Engine is processing a block |
| eng_done | input | 1 | One-cycle strobe: the operation has completed |
| rd_dout | input | 1 | Bus read of the result register |
| wr_din | input | 1 | Bus write to the data-input register |
| wr_key | input | 1 | Bus write to the key register |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| ien_wr | input | 1 | Write strobe for the local interrupt enable |
| ien_wdata | input | 1 | Value written to the local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| ien | output | 1 | Current local interrupt enable |
| rdy_flag | output | 1 | Ready flag |
| irq | output | 1 | Interrupt request |
| clk_req | output | 1 | Main clock request |

## Verification
The flag and the enable are single registers, so their effects appear one rising edge after the stimulus cycle. `irq` and the rising edge of `clk_req` are combinational and are due in the same cycle. The falling edge of `clk_req` comes one edge after `eng_busy` drops.

The bench drives inputs at the falling edge. Registered results are sampled 1 ns after the next rising edge, while the stimulus is still held, so `irq` is compared against the freshly updated flag and the current `gie`. The same-cycle behaviour of `clk_req` is checked 1 ns after the falling edge that drives `eng_busy`, before any rising edge can affect it.

// File: rtl/crypto_irq_pkg.sv
// Package: shared constants for the crypto ready interrupt controller.
// Assumes: the clear-event vector is indexed by the positions below.
package crypto_irq_pkg;
    localparam int CRI_NUM_CLR   = 4;  // number of flag-clearing bus events
    localparam int CRI_CLR_ACK   = 0;
    localparam int CRI_CLR_RDOUT = 1;
    localparam int CRI_CLR_WRDIN = 2;
    localparam int CRI_CLR_WRKEY = 3;
    localparam int CRI_HOLD_CYC  = 1;  // clock request hold after busy falls
endpackage

// File: rtl/cri_ready_flag.sv
// Module: cri_ready_flag
// Holds the completion flag. Priority: power-up reset, software reset,
// set, then clear. Assumes all inputs are synchronous to clk.
module cri_ready_flag #(
    parameter int NUM_CLR = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sw_rst,
    input  logic               set_i,
    input  logic [NUM_CLR-1:0] clr_i,
    output logic               flag_o
);
    logic any_clr;

    // Collapse all clear sources into one event.
    always_comb begin
        any_clr = 1'b0;
        for (int i = 0; i < NUM_CLR; i++) begin
            any_clr = any_clr | clr_i[i];
        end
    end

    // Flag register; set beats clear so that no completion is dropped.
    always_ff @(posedge clk) begin
        if (!por_n)       flag_o <= 1'b0;
        else if (sw_rst)  flag_o <= 1'b0;
        else if (set_i)   flag_o <= 1'b1;
        else if (any_clr) flag_o <= 1'b0;
    end
endmodule

// File: rtl/cri_irq_enable.sv
// Module: cri_irq_enable
// Local interrupt enable bit, written through a strobe. Cleared only by
// power-up reset; the software reset does not reach this module.
module cri_irq_enable (
    input  logic clk,
    input  logic por_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic en_o
);
    // Enable register with write strobe.
    always_ff @(posedge clk) begin
        if (!por_n)    en_o <= 1'b0;
        else if (wr_i) en_o <= wdata_i;
    end
endmodule

// File: rtl/cri_clk_request.sv
// Module: cri_clk_request
// Requests the main clock while the engine is busy, and for HOLD_CYC
// cycles after busy falls. Assumes busy is synchronous to clk.
module cri_clk_request #(
    parameter int HOLD_CYC = 1
) (
    input  logic clk,
    input  logic por_n,
    input  logic busy_i,
    output logic req_o
);
    generate
        if (HOLD_CYC == 0) begin : g_nohold
            // No hold stage: the request follows busy directly.
            assign req_o = busy_i;
        end else begin : g_hold
            logic [HOLD_CYC-1:0] busy_sr;

            // Shift busy history through the hold stages.
            always_ff @(posedge clk) begin
                if (!por_n) busy_sr <= '0;
                else        busy_sr <= {busy_sr[HOLD_CYC-1:0], busy_i} >> 0;
            end

            // Request is live now or from any recent busy cycle.
            assign req_o = busy_i | (|busy_sr);
        end
    endgenerate
endmodule

// File: rtl/crypto_rdy_irq_ctrl.sv
// Module: crypto_rdy_irq_ctrl (top)
// Ready flag, interrupt request and clock request beside a cipher engine.
// Assumes one-cycle strobes for done, bus accesses and acknowledge.
module crypto_rdy_irq_ctrl
    import crypto_irq_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic sw_rst,
    input  logic eng_busy,
    input  logic eng_done,
    input  logic rd_dout,
    input  logic wr_din,
    input  logic wr_key,
    input  logic irq_ack,
    input  logic ien_wr,
    input  logic ien_wdata,
    input  logic gie,
    output logic ien,
    output logic rdy_flag,
    output logic irq,
    output logic clk_req
);
    logic [CRI_NUM_CLR-1:0] clr_vec;

    // Gather the flag-clearing events into one vector.
    always_comb begin
        clr_vec                = '0;
        clr_vec[CRI_CLR_ACK]   = irq_ack;
        clr_vec[CRI_CLR_RDOUT] = rd_dout;
        clr_vec[CRI_CLR_WRDIN] = wr_din;
        clr_vec[CRI_CLR_WRKEY] = wr_key;
    end

    cri_ready_flag #(.NUM_CLR(CRI_NUM_CLR)) flag_i (
        .clk    (clk),
        .por_n  (por_n),
        .sw_rst (sw_rst),
        .set_i  (eng_done),
        .clr_i  (clr_vec),
        .flag_o (rdy_flag)
    );

    cri_irq_enable ien_i (
        .clk     (clk),
        .por_n   (por_n),
        .wr_i    (ien_wr),
        .wdata_i (ien_wdata),
        .en_o    (ien)
    );

    cri_clk_request #(.HOLD_CYC(CRI_HOLD_CYC)) creq_i (
        .clk    (clk),
        .por_n  (por_n),
        .busy_i (eng_busy),
        .req_o  (clk_req)
    );

    // Interrupt request gated by the local and global enables.
    assign irq = rdy_flag & ien & gie;
endmodule

// File: rtl/crypto_rdy_irq_ctrl_chk.sv
// Module: crypto_rdy_irq_ctrl_chk
// Property checker bound to the top module. Observes its ports only.
module crypto_rdy_irq_ctrl_chk (
    input logic clk,
    input logic por_n,
    input logic sw_rst,
    input logic eng_busy,
    input logic eng_done,
    input logic rd_dout,
    input logic wr_din,
    input logic wr_key,
    input logic irq_ack,
    input logic ien_wr,
    input logic ien_wdata,
    input logic gie,
    input logic ien,
    input logic rdy_flag,
    input logic irq,
    input logic clk_req
);
    logic any_clr;
    assign any_clr = rd_dout | wr_din | wr_key | irq_ack;

    assert_done_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
        (eng_done && !sw_rst) |=> rdy_flag);

    assert_clear_events_R3: assert property (@(posedge clk) disable iff (!por_n)
        (any_clr && !eng_done && !sw_rst) |=> !rdy_flag);

    assert_swrst_clears_R5: assert property (@(posedge clk) disable iff (!por_n)
        sw_rst |=> !rdy_flag);

    assert_swrst_keeps_en_R6: assert property (@(posedge clk) disable iff (!por_n)
        (sw_rst && !ien_wr) |=> $stable(ien));

    assert_en_write_R7: assert property (@(posedge clk) disable iff (!por_n)
        ien_wr |=> (ien == $past(ien_wdata)));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> (rdy_flag && ien && gie));

    assert_busy_req_R9: assert property (@(posedge clk) disable iff (!por_n)
        eng_busy |-> clk_req);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        $fell(eng_busy) |-> clk_req);

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        (!eng_done && !sw_rst && !any_clr) |=> $stable(rdy_flag));
endmodule

bind crypto_rdy_irq_ctrl crypto_rdy_irq_ctrl_chk chk_i (
    .clk       (clk),
    .por_n     (por_n),
    .sw_rst    (sw_rst),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .rd_dout   (rd_dout),
    .wr_din    (wr_din),
    .wr_key    (wr_key),
    .irq_ack   (irq_ack),
    .ien_wr    (ien_wr),
    .ien_wdata (ien_wdata),
    .gie       (gie),
    .ien       (ien),
    .rdy_flag  (rdy_flag),
    .irq       (irq),
    .clk_req   (clk_req)
);

// File: tb/crypto_rdy_irq_ctrl_tb_top.sv
// Bench: table-driven walk followed by directed reset and clock-request tests.
module crypto_rdy_irq_ctrl_tb_top;
    logic clk = 1'b0;
    logic por_n, sw_rst, eng_busy, eng_done, rd_dout, wr_din, wr_key;
    logic irq_ack, ien_wr, ien_wdata, gie;
    logic ien, rdy_flag, irq, clk_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit run_done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    crypto_rdy_irq_ctrl dut_i (
        .clk(clk), .por_n(por_n), .sw_rst(sw_rst), .eng_busy(eng_busy),
        .eng_done(eng_done), .rd_dout(rd_dout), .wr_din(wr_din),
        .wr_key(wr_key), .irq_ack(irq_ack), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .gie(gie), .ien(ien), .rdy_flag(rdy_flag),
        .irq(irq), .clk_req(clk_req)
    );

    // Row: sw,done,busy,rd,din,key,ack,ienwr,ienwd,gie | flag,ien,irq,clkreq
    localparam int NROW = 17;
    localparam logic [13:0] VEC [NROW] = '{
        14'b0100000000_1000, // R2 done sets flag, ien still 0
        14'b0000000111_1110, // R7 enable write; R8 irq rises
        14'b0001000001_0100, // R3 result read clears
        14'b0100000001_1110, // R2 set again
        14'b0000100001_0100, // R3 data-in write clears
        14'b0100000001_1110, // R2
        14'b0000010001_0100, // R3 key write clears
        14'b0100000001_1110, // R2
        14'b0000001001_0100, // R3 acknowledge clears
        14'b0100001001_1110, // R4 done with acknowledge: set wins
        14'b0000000000_1100, // R8 gie low masks irq; R10 flag holds
        14'b0010000001_1111, // R9 busy raises clk_req; R10 holds
        14'b1000000001_0100, // R5 sw reset clears flag; R6 ien kept
        14'b1100000001_0100, // R5 sw reset beats done; R6
        14'b0100000001_1110, // R2
        14'b0000000101_1000, // R7 write 0 to enable; R8 irq drops
        14'b0000000001_1000  // R10 flag holds when idle
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_rst = 0; eng_busy = 0; eng_done = 0; rd_dout = 0; wr_din = 0;
        wr_key = 0; irq_ack = 0; ien_wr = 0; ien_wdata = 0; gie = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        por_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check({rdy_flag, ien, irq, clk_req} == 4'b0000, "R1 reset state",
              {rdy_flag, ien, irq, clk_req}, 0);
        @(negedge clk) por_n = 1;

        // Table walk: drive at the falling edge, sample after the rising edge.
        for (int k = 0; k < NROW; k++) begin
            @(negedge clk);
            {sw_rst, eng_done, eng_busy, rd_dout, wr_din, wr_key, irq_ack,
             ien_wr, ien_wdata, gie} = VEC[k][13:4];
            @(posedge clk);
            #1;
            check({rdy_flag, ien, irq, clk_req} == VEC[k][3:0],
                  $sformatf("table row %0d (requirement in row comment)", k),
                  {rdy_flag, ien, irq, clk_req}, VEC[k][3:0]);
        end

        // R8: irq follows gie with no register.
        @(negedge clk); idle_inputs(); eng_done = 1; ien_wr = 1; ien_wdata = 1; gie = 1;
        @(negedge clk); idle_inputs(); gie = 1;
        #1 check(irq == 1'b1, "R8 irq with gie high", irq, 1);
        gie = 0;
        #1 check(irq == 1'b0, "R8 irq drops with gie same cycle", irq, 0);

        // R1: power-up reset mid-run clears flag and enable.
        @(negedge clk); idle_inputs(); eng_busy = 1; por_n = 0;
        @(negedge clk); eng_busy = 0;
        @(posedge clk); #1;
        check({rdy_flag, ien, irq, clk_req} == 4'b0000, "R1 reset mid-run",
              {rdy_flag, ien, irq, clk_req}, 0);
        @(negedge clk) por_n = 1;

        // R9: clock request timing around a busy pulse.
        @(negedge clk); eng_busy = 1;
        #1 check(clk_req == 1'b1, "R9 request in first busy cycle", clk_req, 1);
        @(negedge clk); eng_busy = 0;
        #1 check(clk_req == 1'b1, "R9 request held after busy falls", clk_req, 1);
        @(posedge clk); #1;
        check(clk_req == 1'b0, "R9 request released", clk_req, 0);

        // R4/R3: all clear sources at once with done still sets.
        @(negedge clk); eng_done = 1; rd_dout = 1; wr_din = 1; wr_key = 1; irq_ack = 1;
        @(posedge clk); #1;
        check(rdy_flag == 1'b1, "R4 done beats all clears", rdy_flag, 1);
        @(negedge clk); eng_done = 0;
        @(posedge clk); #1;
        check(rdy_flag == 1'b0, "R3 all clears together", rdy_flag, 0);

        // R6: software reset keeps an enable of 1.
        @(negedge clk); idle_inputs(); ien_wr = 1; ien_wdata = 1;
        @(negedge clk); idle_inputs(); sw_rst = 1;
        @(posedge clk); #1;
        check(ien == 1'b1, "R6 enable survives software reset", ien, 1);

        @(negedge clk); idle_inputs();
        run_done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule